// File: doc/BRIEF.md
# Host Write Receiver for a 4/8-bit Parallel Command Bus

This block sits behind the parallel host port of a character display controller. A host drives a register-select line and a data bus, and marks each write with a pulse on an enable line. The block samples each write, assembles whole command or data bytes and hands each finished byte on with its register-select value as a one-cycle pulse. It never reads back to the host.

The bus has two widths. In wide mode each enable pulse carries a whole byte on all eight data lines. In narrow mode only the upper four lines are wired, and each byte takes two enable pulses: the upper half of the byte comes first and the lower half second. In a narrow wiring the lower four lines float and are pulled up, so they read as ones. The block tracks the bus width itself. It watches every finished command byte, and when it sees a mode-setting command it takes the new width from that command. After reset the bus is wide. For this reason a narrow host's first mode command arrives as one wide write with its lower bits at one. The host then repeats the command as two halves to set those bits.

Top module: `cmd_bus_rx`

## Requirements
- R1: After reset `out_valid` is low, the bus is in wide (8-bit) mode, and no half-byte is pending.
- R2: A write is taken at the first clock edge at which `bus_en` is sampled low after having been sampled high at the edge before. Holding `bus_en` steady, high or low, takes no write. `out_valid` is high for exactly the one cycle that follows the edge that completes a byte.
- R3: In wide mode each write completes a byte. `out_byte` equals `bus_d[7:0]` as sampled at that edge, and `out_rs` equals `bus_rs` as sampled at that edge.
- R4: In narrow mode a byte takes two writes. The first write supplies `out_byte[7:4]` from `bus_d[7:4]` and raises no `out_valid`. The second write supplies `out_byte[3:0]` from its `bus_d[7:4]` and completes the byte.
- R5: In narrow mode `bus_d[3:0]` has no effect on any delivered byte.
- R6: A finished byte with `out_rs` = 0, bits 7..6 = 00 and bit 5 = 1 is a mode command. Bit 4 of that byte selects the width: 1 is wide, 0 is narrow. The new width applies from the very next write.
- R7: A finished byte with `out_rs` = 1 never changes the width, whatever its bit pattern.
- R8: After reset, a single wide write of 0x2F with `bus_rs` = 0 is delivered as 0x2F and switches the bus to narrow mode. The next two writes then form a single byte.
- R9: In narrow mode `out_rs` is the `bus_rs` value of the write that completes the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rs | input | 1 | Register select: 0 command, 1 data |
| bus_en | input | 1 | Write strobe; a write is taken on its falling edge |
| bus_d | input | 8 | Host data lines, bit 7 uppermost |
| out_valid | output | 1 | One-cycle pulse marking a finished byte |
| out_byte | output | 8 | Assembled byte |
| out_rs | output | 1 | Register select belonging to `out_byte` |

## Verification
Two things happen at the same clock edge: a byte is completed, and the width is updated when that byte is a mode command. The write that follows must then be split according to the new width. The bench provokes this by sending a mode command and starting the next write immediately, in both directions: wide to narrow through the 0x2F start-up command, and narrow back to wide through a command sent as two halves. A cycle-accurate reference model in the bench, updated in the same way, judges every `out_valid` cycle and every delivered byte. Any lag in the width update shows up as a misplaced byte boundary.

// File: rtl/cmd_bus_pkg.sv
package cmd_bus_pkg;
  localparam int BYTE_W   = 8;
  localparam int HALF_W   = BYTE_W / 2;
  localparam int WIDE_BIT = 4;
  localparam int CMD_BIT  = 5;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [HALF_W-1:0] half_t;

  function automatic half_t upper_half(input byte_t b);
    return b[BYTE_W-1 -: HALF_W];
  endfunction

  function automatic byte_t join_halves(input half_t hi, input half_t lo);
    return {hi, lo};
  endfunction

  function automatic logic is_width_cmd(input logic rs, input byte_t b);
    return !rs && (b[BYTE_W-1:CMD_BIT+1] == '0) && b[CMD_BIT];
  endfunction
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic fall
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en;
  end

  assign fall = en_q & ~en;
endmodule

// File: rtl/half_joiner.sv
module half_joiner
  import cmd_bus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  wide,
  input  logic  rs,
  input  byte_t d,
  output logic  done,
  output byte_t next_byte,
  output logic  phase,
  output logic  valid,
  output byte_t data,
  output logic  rs_q
);
  half_t hi_q;

  assign done      = take & (wide | phase);
  assign next_byte = wide ? d : join_halves(hi_q, upper_half(d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
      hi_q  <= '0;
      valid <= 1'b0;
      data  <= '0;
      rs_q  <= 1'b0;
    end else begin
      valid <= done;
      if (done) begin
        data  <= next_byte;
        rs_q  <= rs;
        phase <= 1'b0;
      end else if (take) begin
        hi_q  <= upper_half(d);
        phase <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/width_ctrl.sv
module width_ctrl
  import cmd_bus_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  done,
  input  logic  rs,
  input  byte_t next_byte,
  output logic  wide
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      wide <= 1'b1;
    else if (done && is_width_cmd(rs, next_byte))
      wide <= next_byte[WIDE_BIT];
  end
endmodule

// File: rtl/cmd_bus_rx.sv
module cmd_bus_rx
  import cmd_bus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rs,
  input  logic              bus_en,
  input  logic [BYTE_W-1:0] bus_d,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_rs
);
  logic  take;
  logic  done;
  logic  phase;
  logic  wide;
  byte_t next_byte;

  strobe_edge u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (bus_en),
    .fall (take)
  );

  half_joiner u_join (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .wide     (wide),
    .rs       (bus_rs),
    .d        (bus_d),
    .done     (done),
    .next_byte(next_byte),
    .phase    (phase),
    .valid    (out_valid),
    .data     (out_byte),
    .rs_q     (out_rs)
  );

  width_ctrl u_width (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .rs       (bus_rs),
    .next_byte(next_byte),
    .wide     (wide)
  );
endmodule

// File: rtl/cmd_bus_rx_chk.sv
module cmd_bus_rx_chk
  import cmd_bus_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  bus_en,
  input byte_t bus_d,
  input logic  take,
  input logic  done,
  input logic  wide,
  input logic  phase,
  input logic  out_valid,
  input byte_t out_byte,
  input logic  out_rs
);
  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid && wide && !phase); // R1
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |=> !out_valid); // R2
  AST_PULSE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!$past(bus_en) && $past(bus_en, 2))); // R2
  AST_WIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && wide) |=> (out_valid && out_byte == $past(bus_d))); // R3
  AST_FIRST_HALF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wide && !phase) |=> (!out_valid && phase)); // R4
  AST_CMD_SETS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_rs && out_byte[7:6] == 2'b00 && out_byte[5]) |-> (wide == out_byte[4])); // R6
  AST_DATA_KEEPS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_rs) |-> $stable(wide)); // R7
endmodule

bind cmd_bus_rx cmd_bus_rx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_d    (bus_d),
  .take     (take),
  .done     (done),
  .wide     (wide),
  .phase    (phase),
  .out_valid(out_valid),
  .out_byte (out_byte),
  .out_rs   (out_rs)
);

// File: tb/sim_cmd_bus_rx.sv
`timescale 1ns/1ps
module sim_cmd_bus_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rs = 1'b0;
  logic       bus_en = 1'b0;
  logic [7:0] bus_d = 8'h00;
  logic       out_valid;
  logic [7:0] out_byte;
  logic       out_rs;

  cmd_bus_rx u0 (
    .clk(clk), .rst_n(rst_n), .bus_rs(bus_rs), .bus_en(bus_en), .bus_d(bus_d),
    .out_valid(out_valid), .out_byte(out_byte), .out_rs(out_rs)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int issued = 0;
  int taken = 0;
  int cycles = 0;
  bit finished = 0;
  string tag = "R2";

  // behavioural reference
  int   ref_wide = 1;
  int   ref_ph = 0;
  int   ref_hi = 0;
  logic [7:0] q_byte[$];
  logic       q_rs[$];

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(input logic rs, input logic [7:0] d);
    int full;
    full = -1;
    if (ref_wide != 0) full = d;
    else if (ref_ph == 0) begin ref_hi = d / 16; ref_ph = 1; end
    else begin full = ref_hi * 16 + d / 16; ref_ph = 0; end
    if (full >= 0) begin
      q_byte.push_back(full[7:0]);
      q_rs.push_back(rs);
      if (rs == 0 && full / 32 == 1) ref_wide = (full / 16) % 2;
      issued++;
    end
  endtask

  task automatic wr(input logic rs, input logic [7:0] d);
    @(negedge clk);
    bus_rs = rs; bus_d = d; bus_en = 1'b1;
    @(negedge clk);
    bus_en = 1'b0;
    model(rs, d);
  endtask

  // per-clock comparison against the model
  always @(posedge clk) begin
    bit pend;
    pend = (issued > taken);
    taken = issued;
    #1;
    if (rst_n && !finished) begin
      check({tag, " valid"}, out_valid, pend);
      if (pend && out_valid && q_byte.size() > 0) begin
        check({tag, " byte"}, out_byte, q_byte.pop_front());
        check({tag, " rs"}, out_rs, q_rs.pop_front());
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    bus_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_en = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 valid", out_valid, 0);
    tag = "R1";
    wr(1'b1, 8'hA5);                       // R1: first write delivered whole
    repeat (2) @(negedge clk);

    tag = "R3";                            // R3: wide bytes
    wr(1'b1, 8'h3C); wr(1'b0, 8'h01); wr(1'b1, 8'hFF); wr(1'b0, 8'h80);

    tag = "R7";                            // R7: data byte shaped like a command
    wr(1'b1, 8'h20); wr(1'b1, 8'h77);

    tag = "R10";                           // R2: held enable takes nothing
    tag = "R2";
    @(negedge clk); bus_en = 1'b1; bus_d = 8'h11;
    repeat (6) @(negedge clk);
    bus_en = 1'b0;
    model(bus_rs, bus_d);
    repeat (6) @(negedge clk);

    tag = "R8";                            // R8: start-up command with pulled-up lows
    wr(1'b0, 8'h2F);
    check("R8 narrow", ref_wide, 0);
    tag = "R4";                            // R4: two halves per byte, started at once
    wr(1'b1, 8'h4F); wr(1'b1, 8'h1F);
    wr(1'b0, 8'hC0); wr(1'b0, 8'h3A);
    tag = "R5";                            // R5: low lines are noise
    wr(1'b1, 8'h95); wr(1'b1, 8'h6A);
    wr(1'b1, 8'h00); wr(1'b1, 8'hFF);
    tag = "R9";                            // R9: rs of completing half
    wr(1'b0, 8'h5F); wr(1'b1, 8'hEF);
    tag = "R7";
    wr(1'b1, 8'h3F); wr(1'b1, 8'h0F);      // 0x30 as data, stays narrow
    wr(1'b1, 8'hAF); wr(1'b1, 8'hBF);
    tag = "R6";                            // R6: narrow -> wide via 0x38 in halves
    wr(1'b0, 8'h3F); wr(1'b0, 8'h8F);
    wr(1'b1, 8'hD2); wr(1'b1, 8'h2D);      // wide immediately
    wr(1'b0, 8'h2C);                       // wide -> narrow again
    wr(1'b1, 8'h7F); wr(1'b1, 8'h3F);
    for (int i = 0; i < 20; i++) wr(i[0], 8'(i * 37 + 5));
    repeat (4) @(negedge clk);
    check("R6 queue empty", q_byte.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule